// File: doc/BRIEF.md
# Masked Vector Element Shift Unit

This block shifts every element of a packed vector register in one registered step. The register is `VLEN` bits wide. The selected element width (8, 16, 32 or 64 bits) decides how the register splits into elements. Three operations are available: logical left shift, logical right shift with zero fill, and arithmetic right shift with sign fill. Each element takes its shift amount either from the matching element of an amount vector or from one scalar shared by all elements. In both cases only the low log2(width) bits of the amount are used.

Two controls decide what is written into each destination element. The active length `vl` limits processing to the low elements, and the elements above it are cleared to zero. An optional mask makes the disabled elements keep the old destination value. A one-cycle `start_i` pulse captures the inputs. The new destination value appears on `result_o` at that clock edge, and `done_o` is high for the following cycle. The result holds until the next start.

Top module: `vshift_unit`

## Requirements
- R1: `sew_i` selects the element width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. Element i occupies bits [i*SEW +: SEW], with the least significant element first, and the register holds VLEN/SEW elements.
- R2: Only the low log2(SEW) bits of a shift amount are used: 3, 4, 5 or 6 bits for the four widths.
- R3: `op_i` = 0 gives a logical left shift of each element. Bits shifted past the element's top bit are discarded.
- R4: `op_i` = 1 (and the unused code 3) gives a logical right shift that fills with zeros.
- R5: `op_i` = 2 gives an arithmetic right shift that fills with the source element's sign bit.
- R6: With `scalar_mode_i` = 0, element i is shifted by element i of `amt_i`. With `scalar_mode_i` = 1, every element is shifted by `scalar_i`, and `amt_i` has no effect.
- R7: With `mask_en_i` = 1 and `mask_i[i]` = 0, destination element i keeps its value from `old_i`.
- R8: With `mask_en_i` = 0, every element below vl is written, whatever `mask_i` holds.
- R9: Elements with index from vl up to VLEN/SEW-1 are cleared to zero.
- R10: A vl larger than VLEN/SEW acts as VLEN/SEW.
- R11: A `start_i` pulse loads `result_o` at that clock edge and raises `done_o` for exactly one cycle. Without a start, `result_o` holds its value and `done_o` stays low.
- R12: During reset, `result_o` is zero and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture inputs and produce a result |
| op_i | input | 2 | 0 left logical, 1 right logical, 2 right arithmetic, 3 right logical |
| scalar_mode_i | input | 1 | 1 = shift by scalar_i, 0 = shift by amt_i elements |
| sew_i | input | 2 | Element width code (8 << sew_i bits) |
| vl_i | input | VL_W | Active element count |
| old_i | input | VLEN | Previous destination register contents |
| src_i | input | VLEN | Source vector to shift |
| amt_i | input | VLEN | Per-element shift-amount vector |
| scalar_i | input | 64 | Scalar shift amount |
| mask_i | input | VLEN/8 | Mask register, one bit per element index |
| mask_en_i | input | 1 | 1 = apply mask_i |
| result_o | output | VLEN | New destination register |
| done_o | output | 1 | High for one cycle after a start |

## Verification
The bench uses amounts that exceed the element width, such as 9 for 8-bit elements. A design that does not truncate the amount would clear those elements instead of shifting them by 1. Negative elements shifted right by the largest legal amount at 64-bit width must come out all ones. A fill bit of zero, or a fill taken from the wrong lane, shows up as a wrong element. The directed tests cover a vl of zero, a vl exactly at capacity and a vl far above capacity. A design that mishandled any of these would leak source data into the tail or clear live elements. The mask is checked in both modes, and the scalar path is checked against a conflicting amount vector. These two checks catch a design that ignores the mask-enable or reads the wrong amount source.

// File: rtl/vshift_pkg.sv
package vshift_pkg;
  typedef enum logic [1:0] {
    OP_SLL = 2'd0,
    OP_SRL = 2'd1,
    OP_SRA = 2'd2,
    OP_RSV = 2'd3
  } shop_e;

  localparam int unsigned SEW_VARIANTS = 4;
  localparam int unsigned MAX_SEW      = 64;
endpackage

// File: rtl/vshift_elem.sv
module vshift_elem
  import vshift_pkg::*;
#(
  parameter int unsigned SEW  = 8,
  localparam int unsigned AW  = $clog2(SEW)
) (
  input  shop_e            op_i,
  input  logic [SEW-1:0]   src_i,
  input  logic [SEW-1:0]   old_i,
  input  logic [AW-1:0]    amt_i,
  input  logic             active_i,
  input  logic             keep_i,
  output logic [SEW-1:0]   res_o
);
  logic [SEW-1:0] shifted;

  always_comb begin
    unique case (op_i)
      OP_SLL:  shifted = src_i << amt_i;
      OP_SRA:  shifted = $unsigned($signed(src_i) >>> amt_i);
      default: shifted = src_i >> amt_i;
    endcase
  end

  // tail clears, masked-off keeps old
  always_comb begin
    if (!active_i)   res_o = '0;
    else if (keep_i) res_o = old_i;
    else             res_o = shifted;
  end
endmodule

// File: rtl/vshift_path.sv
module vshift_path
  import vshift_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  parameter int unsigned SEW  = 8,
  parameter int unsigned VL_W = 8,
  localparam int unsigned N   = VLEN / SEW,
  localparam int unsigned AW  = $clog2(SEW)
) (
  input  shop_e             op_i,
  input  logic              scalar_mode_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [VLEN-1:0]   old_i,
  input  logic [VLEN-1:0]   src_i,
  input  logic [VLEN-1:0]   amt_i,
  input  logic [AW-1:0]     scalar_i,
  input  logic [N-1:0]      mask_i,
  input  logic              mask_en_i,
  output logic [VLEN-1:0]   res_o
);
  logic [VLEN-1:0] unused_amt;
  assign unused_amt = amt_i;

  for (genvar i = 0; i < N; i++) begin : g_elem
    logic [AW-1:0] amt_sel;
    logic          active;
    logic          keep;

    assign amt_sel = scalar_mode_i ? scalar_i : amt_i[i*SEW +: AW];
    // i < N always, so vl above capacity is clamped implicitly
    assign active  = {1'b0, vl_i} > (VL_W+1)'(i);
    assign keep    = mask_en_i & ~mask_i[i];

    vshift_elem #(.SEW(SEW)) u_elem (
      .op_i     (op_i),
      .src_i    (src_i[i*SEW +: SEW]),
      .old_i    (old_i[i*SEW +: SEW]),
      .amt_i    (amt_sel),
      .active_i (active),
      .keep_i   (keep),
      .res_o    (res_o[i*SEW +: SEW])
    );
  end
endmodule

// File: rtl/vshift_unit.sv
module vshift_unit
  import vshift_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  parameter int unsigned VL_W = 8,
  localparam int unsigned MAX_ELEMS = VLEN / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              scalar_mode_i,
  input  logic [1:0]        sew_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [VLEN-1:0]   old_i,
  input  logic [VLEN-1:0]   src_i,
  input  logic [VLEN-1:0]   amt_i,
  input  logic [63:0]       scalar_i,
  input  logic [MAX_ELEMS-1:0] mask_i,
  input  logic              mask_en_i,
  output logic [VLEN-1:0]   result_o,
  output logic              done_o
);
  shop_e           op;
  logic [VLEN-1:0] path_res [SEW_VARIANTS];
  logic [VLEN-1:0] next_res;
  logic [63:0]     unused_scalar;

  assign op            = shop_e'(op_i);
  assign unused_scalar = scalar_i;

  for (genvar s = 0; s < SEW_VARIANTS; s++) begin : g_sew
    localparam int unsigned SEW = 8 << s;
    localparam int unsigned N   = VLEN / SEW;
    localparam int unsigned AW  = $clog2(SEW);

    vshift_path #(.VLEN(VLEN), .SEW(SEW), .VL_W(VL_W)) u_path (
      .op_i          (op),
      .scalar_mode_i (scalar_mode_i),
      .vl_i          (vl_i),
      .old_i         (old_i),
      .src_i         (src_i),
      .amt_i         (amt_i),
      .scalar_i      (scalar_i[AW-1:0]),
      .mask_i        (mask_i[N-1:0]),
      .mask_en_i     (mask_en_i),
      .res_o         (path_res[s])
    );
  end

  assign next_res = path_res[sew_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) result_o <= next_res;
    end
  end
endmodule

// File: rtl/vshift_unit_chk.sv
module vshift_unit_chk
  import vshift_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  parameter int unsigned VL_W = 8,
  localparam int unsigned MAX_ELEMS = VLEN / 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic [1:0]           op_i,
  input logic                 scalar_mode_i,
  input logic [1:0]           sew_i,
  input logic [VL_W-1:0]      vl_i,
  input logic [VLEN-1:0]      old_i,
  input logic [VLEN-1:0]      src_i,
  input logic [VLEN-1:0]      amt_i,
  input logic [MAX_ELEMS-1:0] mask_i,
  input logic                 mask_en_i,
  input logic [VLEN-1:0]      result_o,
  input logic                 done_o
);
  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (!done_o && $stable(result_o)));

  // vl = 0 leaves no active element: all tail
  assert_tail_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && vl_i == '0) |=> result_o == '0);

  // all-zero mask with full vl returns old register
  assert_mask_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mask_en_i && mask_i == '0 && vl_i >= VL_W'(MAX_ELEMS))
      |=> result_o == $past(old_i));

  // zero per-element amounts, unmasked, full vl: source passes through
  assert_zero_amt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !scalar_mode_i && !mask_en_i && amt_i == '0 &&
     vl_i >= VL_W'(MAX_ELEMS)) |=> result_o == $past(src_i));

  logic unused_chk;
  assign unused_chk = ^{op_i, sew_i};
endmodule

bind vshift_unit vshift_unit_chk #(.VLEN(VLEN), .VL_W(VL_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .op_i          (op_i),
  .scalar_mode_i (scalar_mode_i),
  .sew_i         (sew_i),
  .vl_i          (vl_i),
  .old_i         (old_i),
  .src_i         (src_i),
  .amt_i         (amt_i),
  .mask_i        (mask_i),
  .mask_en_i     (mask_en_i),
  .result_o      (result_o),
  .done_o        (done_o)
);

// File: tb/vshift_unit_tb.sv
module vshift_unit_tb;
  localparam int unsigned VLEN = 128;
  localparam int unsigned VL_W = 8;
  localparam int unsigned ME   = VLEN / 8;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [1:0]      op_i = '0;
  logic            scalar_mode_i = 1'b0;
  logic [1:0]      sew_i = '0;
  logic [VL_W-1:0] vl_i = '0;
  logic [VLEN-1:0] old_i = '0, src_i = '0, amt_i = '0;
  logic [63:0]     scalar_i = '0;
  logic [ME-1:0]   mask_i = '0;
  logic            mask_en_i = 1'b0;
  logic [VLEN-1:0] result_o;
  logic            done_o;

  int checks = 0;
  int failures = 0;

  always #10 clk_i = ~clk_i;

  vshift_unit #(.VLEN(VLEN), .VL_W(VL_W)) u_dut (.*);

  function automatic logic [VLEN-1:0] ref_model(
    input logic [1:0] op, input logic scal, input logic [1:0] sew, input int vl,
    input logic [VLEN-1:0] old, input logic [VLEN-1:0] src, input logic [VLEN-1:0] amt,
    input logic [63:0] scalar, input logic [ME-1:0] mask, input logic men);
    int w = 8 << sew;
    int n = VLEN / w;
    logic [63:0] wm = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    logic [VLEN-1:0] res = '0;
    for (int i = 0; i < n; i++) begin
      logic [63:0] e, o, sa, v;
      e  = 64'(src >> (i*w)) & wm;
      o  = 64'(old >> (i*w)) & wm;
      sa = (scal ? scalar : 64'(amt >> (i*w))) & 64'(w - 1);
      if (i >= vl) v = '0;
      else if (men && !mask[i]) v = o;
      else begin
        case (op)
          2'd0: v = (e << sa) & wm;
          2'd2: begin
            v = e[w-1] ? (e | ~wm) : e;
            v = 64'($signed(v) >>> sa) & wm;
          end
          default: v = e >> sa;
        endcase
      end
      res |= VLEN'(v) << (i*w);
    end
    return res;
  endfunction

  task automatic check(input string tag, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, capture at posedge, sample at next negedge
  task automatic run_op(input string tag, input logic [1:0] op, input logic scal,
    input logic [1:0] sew, input logic [VL_W-1:0] vl, input logic [VLEN-1:0] old,
    input logic [VLEN-1:0] src, input logic [VLEN-1:0] amt, input logic [63:0] scalar,
    input logic [ME-1:0] mask, input logic men, output logic [VLEN-1:0] got);
    op_i = op; scalar_mode_i = scal; sew_i = sew; vl_i = vl; old_i = old;
    src_i = src; amt_i = amt; scalar_i = scalar; mask_i = mask; mask_en_i = men;
    start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    got = result_o;
    check({tag, " R11 done"}, {127'd0, done_o}, 128'd1);
    check(tag, got, ref_model(op, scal, sew, int'(vl), old, src, amt, scalar, mask, men));
  endtask

  task automatic t_reset;
    check("R12 reset result", result_o, '0);
    check("R12 reset done", {127'd0, done_o}, '0);
  endtask

  task automatic t_shifts;
    logic [VLEN-1:0] g, amt;
    for (int s = 0; s < 4; s++) begin
      amt = '0;
      for (int i = 0; i < ME; i++) amt[i*8 +: 8] = 8'(i * 3);
      run_op("R1 R3 sll", 2'd0, 1'b0, 2'(s), 8'd16, '0, {4{32'h8123_F0A5}}, amt, 0, '0, 1'b0, g);
      run_op("R1 R4 srl", 2'd1, 1'b0, 2'(s), 8'd16, '0, {4{32'h8123_F0A5}}, amt, 0, '0, 1'b0, g);
      run_op("R1 R5 sra", 2'd2, 1'b0, 2'(s), 8'd16, '0, {4{32'hF123_80A5}}, amt, 0, '0, 1'b0, g);
      run_op("R4 op3", 2'd3, 1'b0, 2'(s), 8'd16, '0, {4{32'hF123_80A5}}, amt, 0, '0, 1'b0, g);
    end
  endtask

  task automatic t_literals;
    logic [VLEN-1:0] g;
    // sew8 amount 9 truncates to 1: 0x81<<1 = 0x02
    run_op("R2 trunc8", 2'd0, 1'b1, 2'd0, 8'd16, '0, {16{8'h81}}, '0, 64'd9, '0, 1'b0, g);
    check("R2 trunc8 literal", g, {16{8'h02}});
    // sew64 sra by 63 of negative element gives all ones; positive gives 0
    run_op("R5 sra64", 2'd2, 1'b1, 2'd3, 8'd2, '0, {64'h7FFF_0000_0000_0000, 64'h8000_0000_0000_0000},
           '0, 64'd63, '0, 1'b0, g);
    check("R5 sra64 literal", g, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF});
    // sew16 srl amount 20 -> 4, zero fill
    run_op("R4 srl16", 2'd1, 1'b1, 2'd1, 8'd8, '0, {8{16'hF000}}, '0, 64'd20, '0, 1'b0, g);
    check("R4 srl16 literal", g, {8{16'h0F00}});
    // sew32 per-element amount 33 -> 1
    run_op("R2 trunc32", 2'd0, 1'b0, 2'd2, 8'd4, '0, {4{32'hC000_0001}}, {4{32'd33}}, 0, '0, 1'b0, g);
    check("R2 trunc32 literal", g, {4{32'h8000_0002}});
  endtask

  task automatic t_scalar;
    logic [VLEN-1:0] g;
    // amt vector all 7 but scalar 1 is used
    run_op("R6 scalar", 2'd0, 1'b1, 2'd0, 8'd16, '0, {16{8'h11}}, {16{8'h07}}, 64'd1, '0, 1'b0, g);
    check("R6 scalar literal", g, {16{8'h22}});
    run_op("R6 vector", 2'd0, 1'b0, 2'd0, 8'd16, '0, {16{8'h11}}, {16{8'h02}}, 64'd1, '0, 1'b0, g);
    check("R6 vector literal", g, {16{8'h44}});
  endtask

  task automatic t_mask;
    logic [VLEN-1:0] g;
    run_op("R7 mask", 2'd0, 1'b1, 2'd0, 8'd16, {16{8'hAA}}, {16{8'h01}}, '0, 64'd1, 16'h00FF, 1'b1, g);
    check("R7 mask literal", g, {{8{8'hAA}}, {8{8'h02}}});
    run_op("R7 mask32", 2'd2, 1'b0, 2'd2, 8'd4, {4{32'h5555_5555}}, {4{32'h8000_0000}},
           {4{32'd4}}, 0, 16'h0005, 1'b1, g);
    run_op("R8 unmasked", 2'd0, 1'b1, 2'd0, 8'd16, {16{8'hAA}}, {16{8'h01}}, '0, 64'd1, 16'h0000, 1'b0, g);
    check("R8 unmasked literal", g, {16{8'h02}});
  endtask

  task automatic t_tail;
    logic [VLEN-1:0] g;
    run_op("R9 tail vl0", 2'd1, 1'b1, 2'd1, 8'd0, '1, '1, '0, 64'd0, '1, 1'b1, g);
    check("R9 tail vl0 literal", g, '0);
    run_op("R9 tail vl3", 2'd1, 1'b1, 2'd1, 8'd3, '1, '1, '0, 64'd0, '1, 1'b0, g);
    check("R9 tail vl3 literal", g, {80'h0, {3{16'hFFFF}}});
    run_op("R9 tail masked", 2'd0, 1'b1, 2'd0, 8'd5, '1, {16{8'h01}}, '0, 64'd0, 16'h0001, 1'b1, g);
    check("R9 tail masked literal", g, {88'h0, 40'hFF_FFFF_FF01});
    run_op("R10 clamp", 2'd0, 1'b1, 2'd3, 8'd255, '0, {2{64'h1}}, '0, 64'd4, '0, 1'b0, g);
    check("R10 clamp literal", g, {2{64'h10}});
    run_op("R10 at cap", 2'd0, 1'b1, 2'd0, 8'd16, '0, {16{8'h01}}, '0, 64'd0, '0, 1'b0, g);
    check("R10 at cap literal", g, {16{8'h01}});
  endtask

  task automatic t_hold;
    logic [VLEN-1:0] g;
    run_op("R11 load", 2'd0, 1'b1, 2'd0, 8'd16, '0, {16{8'h03}}, '0, 64'd2, '0, 1'b0, g);
    src_i = '1; scalar_i = 64'd0; vl_i = '0;
    @(negedge clk_i);
    check("R11 hold result", result_o, g);
    check("R11 done single", {127'd0, done_o}, '0);
  endtask

  task automatic t_random;
    logic [VLEN-1:0] g;
    for (int k = 0; k < 60; k++) begin
      run_op("R1 R6 R7 R9 random", 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
             2'($urandom_range(0, 3)), 8'($urandom_range(0, 20)),
             {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
             {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom},
             16'($urandom), 1'($urandom_range(0, 1)), g);
    end
  endtask

  initial begin
    #2000000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_shifts();
    t_literals();
    t_scalar();
    t_mask();
    t_tail();
    t_hold();
    t_random();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule